// File: doc/BRIEF.md
# Asymmetric SCL Timing Generator

This block produces the clock line timing for a two-wire serial master. Its only time base is the peripheral clock. Software programs one 32-bit divider word that holds two independent 16-bit fields, one for the high phase and one for the low phase. Each field is counted in units of eight peripheral clocks, with one unit added. The high and low times can therefore differ, and the clock line does not need a 50% duty cycle.

When the block is enabled, a START hold comes first. During it the line stays high for one low-phase length, so the data line can fall under a high clock. After that the block alternates low and high phases. It gives a single-cycle data-change strobe at the middle of each low phase and a single-cycle sample strobe at the middle of each high phase. A bit engine uses these strobes to place data edges and to sample the data line. The phase length is latched at the moment a phase begins, so a new divider word only takes effect from the next phase. When the block is disabled, it releases the line high and clears its counter.

The controller has four states. IDLE is the disabled, released state. HOLD is the START hold, with the line high. LOW and HIGH are the two halves of each clock period. The transitions are:
- IDLE to HOLD when enable is seen.
- HOLD to LOW when the hold count ends.
- LOW to HIGH when the low count ends.
- HIGH to LOW when the high count ends.
- Any state to IDLE when enable is low.

Top module: `scl_timing_gen`

## Requirements
- R1: While enable is low, and during reset, scl_o is 1 and both tick_change and tick_sample are 0. Dropping enable returns scl_o to 1 one clock later, and the phase counter is cleared.
- R2: div_cfg bits [31:16] hold the high-phase field and bits [15:0] hold the low-phase field.
- R3: Each low phase lasts 8 × (low field + 1) clocks with scl_o at 0.
- R4: Each high phase lasts 8 × (high field + 1) clocks with scl_o at 1.
- R5: After enable rises, scl_o stays 1 for a START hold of 8 × (low field + 1) clocks before the first low phase. No strobe is given during this hold.
- R6: tick_change pulses exactly once per low phase, on clock index 4 × (low field + 1), counting the first low clock as index 0.
- R7: tick_sample pulses exactly once per high phase, on clock index 4 × (high field + 1), counting the first high clock as index 0.
- R8: A div_cfg write during a phase does not change that phase's length. The next phase uses the new value.
- R9: Disabling during a low or a high phase ends it at once. Enabling again always starts with a new full START hold.
- R10: A field value of 0 gives an 8-clock phase with its strobe at index 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the generator when 1; releases the line when 0 |
| div_cfg | input | 32 | Divider word: high field [31:16], low field [15:0] |
| scl_o | output | 1 | Clock line level (1 = released/high) |
| tick_change | output | 1 | Single-cycle strobe at mid low phase |
| tick_sample | output | 1 | Single-cycle strobe at mid high phase |

## Verification
The bench builds the generator with its default parameters: 16-bit fields and 8-clock units. It keeps field values between 0 and 15, so every phase length from 8 to 128 clocks fits in a short run, including the zero-field minimum. Directed cases cover swapped high and low values, a divider write in the middle of a phase, and disabling during each phase. A fixed-seed random sweep of field pairs then measures every run length and strobe position against expected values computed from the field formulas.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_LOW,
        ST_HIGH
    } scl_state_e;

endpackage

// File: rtl/scl_div_decode.sv
module scl_div_decode #(
    parameter int FIELD_W = 16
) (
    input  logic [2*FIELD_W-1:0] div_cfg,
    input  logic                 sel_high,
    output logic [FIELD_W-1:0]   field
);

    logic [FIELD_W-1:0] hi_field;
    logic [FIELD_W-1:0] lo_field;

    // R2: upper half is the high-phase field, lower half the low-phase field
    assign hi_field = div_cfg[2*FIELD_W-1:FIELD_W];
    assign lo_field = div_cfg[FIELD_W-1:0];

    always_comb begin
        field = sel_high ? hi_field : lo_field;
    end

endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
    parameter int FIELD_W   = 16,
    parameter int UNIT_LOG2 = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               load,
    input  logic [FIELD_W-1:0] load_field,
    output logic               at_end,
    output logic               at_mid
);

    localparam int CNT_W = FIELD_W + UNIT_LOG2;

    logic [FIELD_W-1:0] cur_field;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   term_pt;
    logic [CNT_W-1:0]   mid_pt;
    logic [FIELD_W:0]   field_p1;

    // Phase length is latched only on load (R8)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            cur_field <= '0;
        end else if (clear) begin
            cnt       <= '0;
            cur_field <= '0;
        end else if (load) begin
            cnt       <= '0;
            cur_field <= load_field;
        end else begin
            cnt       <= cnt + 1'b1;
        end
    end

    always_comb begin
        field_p1 = {1'b0, cur_field} + {{FIELD_W{1'b0}}, 1'b1};
        term_pt  = {cur_field, {UNIT_LOG2{1'b1}}};
        mid_pt   = {{(UNIT_LOG2-1){1'b0}}, field_p1} << (UNIT_LOG2-1);
        at_end   = (cnt == term_pt);
        at_mid   = (cnt == mid_pt);
    end

    // R1: a clear leaves the counter at zero
    a_r1_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));

    // R3: the counter never runs past the latched terminal count
    a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= term_pt);

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_gen_pkg::*;
#(
    parameter int FIELD_W   = 16,
    parameter int UNIT_LOG2 = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [2*FIELD_W-1:0] div_cfg,
    output logic                 scl_o,
    output logic                 tick_change,
    output logic                 tick_sample
);

    scl_state_e         state_q;
    scl_state_e         state_d;
    logic               cnt_clear;
    logic               cnt_load;
    logic               sel_high;
    logic [FIELD_W-1:0] next_field;
    logic               at_end;
    logic               at_mid;

    scl_div_decode #(
        .FIELD_W (FIELD_W)
    ) u_decode (
        .div_cfg  (div_cfg),
        .sel_high (sel_high),
        .field    (next_field)
    );

    scl_phase_cnt #(
        .FIELD_W   (FIELD_W),
        .UNIT_LOG2 (UNIT_LOG2)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (cnt_clear),
        .load       (cnt_load),
        .load_field (next_field),
        .at_end     (at_end),
        .at_mid     (at_mid)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and counter control
    always_comb begin
        state_d   = state_q;
        cnt_clear = !enable;
        cnt_load  = 1'b0;
        sel_high  = 1'b0;
        if (!enable) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d  = ST_HOLD;
                    cnt_load = 1'b1;
                end
                ST_HOLD: begin
                    if (at_end) begin
                        state_d  = ST_LOW;
                        cnt_load = 1'b1;
                    end
                end
                ST_LOW: begin
                    if (at_end) begin
                        state_d  = ST_HIGH;
                        cnt_load = 1'b1;
                        sel_high = 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (at_end) begin
                        state_d  = ST_LOW;
                        cnt_load = 1'b1;
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        scl_o       = (state_q != ST_LOW);
        tick_change = (state_q == ST_LOW)  && at_mid;
        tick_sample = (state_q == ST_HIGH) && at_mid;
    end

    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_o && !tick_change && !tick_sample));

    a_r5_hold_then_low: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == ST_HOLD && at_end) |=> !scl_o);

    a_r3_low_then_high: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == ST_LOW && at_end) |=> scl_o);

    a_r8_no_mid_phase_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (state_q == ST_LOW || state_q == ST_HIGH) && !at_end)
            |=> $stable(scl_o));

    a_r6_ticks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_change && tick_sample));

    a_r6_change_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        tick_change |-> !scl_o);

    a_r7_sample_in_high: assert property (@(posedge clk) disable iff (!rst_n)
        tick_sample |-> scl_o);

endmodule

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [31:0] div_cfg = '0;
    logic        scl_o;
    logic        tick_change;
    logic        tick_sample;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    scl_timing_gen u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .div_cfg     (div_cfg),
        .scl_o       (scl_o),
        .tick_change (tick_change),
        .tick_sample (tick_sample)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int exp_len(input int f);
        return 8 * (f + 1);
    endfunction

    function automatic int exp_mid(input int f);
        return 4 * (f + 1);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Measures a run of scl_o == lvl starting at the current negedge.
    // Records the position and count of the strobe belonging to that level,
    // and the count of the other strobe. Optionally writes div_cfg at index 2.
    task automatic run_len(input logic lvl, input bit do_wr, input logic [31:0] wr_val,
                           output int n, output int tpos, output int tcnt, output int ocnt);
        n = 0; tpos = -1; tcnt = 0; ocnt = 0;
        while (scl_o == lvl && n < 100000) begin
            if (lvl ? tick_sample : tick_change) begin
                tpos = n;
                tcnt = tcnt + 1;
            end
            if (lvl ? tick_change : tick_sample) ocnt = ocnt + 1;
            if (do_wr && n == 2) div_cfg = wr_val;
            n = n + 1;
            @(negedge clk);
        end
    endtask

    task automatic full_case(input int lo, input int hi);
        int n, tp, tc, oc;
        div_cfg = {hi[15:0], lo[15:0]};
        enable = 1'b1;
        @(negedge clk);
        run_len(1'b1, 1'b0, '0, n, tp, tc, oc);
        chk("R5 hold length", n, exp_len(lo));
        chk("R5 no strobe in hold", tc + oc, 0);
        run_len(1'b0, 1'b0, '0, n, tp, tc, oc);
        chk("R3 low length", n, exp_len(lo));
        chk("R6 change strobe index", tp, exp_mid(lo));
        chk("R6 change strobe count", tc + oc, 1);
        run_len(1'b1, 1'b0, '0, n, tp, tc, oc);
        chk("R4 high length", n, exp_len(hi));
        chk("R7 sample strobe index", tp, exp_mid(hi));
        chk("R7 sample strobe count", tc + oc, 1);
        run_len(1'b0, 1'b0, '0, n, tp, tc, oc);
        chk("R3 second low length", n, exp_len(lo));
        enable = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int n, tp, tc, oc;
        void'($urandom(32'd7715));

        repeat (3) @(negedge clk);
        chk("R1 reset scl", int'(scl_o), 1);
        chk("R1 reset strobes", int'(tick_change) + int'(tick_sample), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 disabled scl", int'(scl_o), 1);

        // R2: asymmetric fields, each way round
        full_case(5, 2);
        full_case(0, 5);
        // R10: minimum phases
        full_case(0, 0);

        // R8: write mid low phase
        div_cfg = {16'd3, 16'd3};
        enable = 1'b1;
        @(negedge clk);
        run_len(1'b1, 1'b0, '0, n, tp, tc, oc);
        run_len(1'b0, 1'b1, {16'd6, 16'd1}, n, tp, tc, oc);
        chk("R8 current low keeps old length", n, exp_len(3));
        run_len(1'b1, 1'b0, '0, n, tp, tc, oc);
        chk("R8 next high uses new field", n, exp_len(6));
        chk("R8 next high strobe", tp, exp_mid(6));
        run_len(1'b0, 1'b0, '0, n, tp, tc, oc);
        chk("R8 next low uses new field", n, exp_len(1));
        enable = 1'b0;
        repeat (2) @(negedge clk);

        // R9: disable during low
        div_cfg = {16'd4, 16'd4};
        enable = 1'b1;
        @(negedge clk);
        run_len(1'b1, 1'b0, '0, n, tp, tc, oc);
        repeat (3) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R9 disable in low releases scl", int'(scl_o), 1);
        tc = 0;
        for (int i = 0; i < 20; i++) begin
            if (!scl_o || tick_change || tick_sample) tc = tc + 1;
            @(negedge clk);
        end
        chk("R1 idle stays released and quiet", tc, 0);
        enable = 1'b1;
        @(negedge clk);
        run_len(1'b1, 1'b0, '0, n, tp, tc, oc);
        chk("R9 re-enable full hold", n, exp_len(4));
        // R9: disable during high
        run_len(1'b0, 1'b0, '0, n, tp, tc, oc);
        repeat (2) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R9 disable in high keeps scl", int'(scl_o), 1);
        enable = 1'b1;
        @(negedge clk);
        run_len(1'b1, 1'b0, '0, n, tp, tc, oc);
        chk("R9 hold after high abort", n, exp_len(4));
        enable = 1'b0;
        repeat (2) @(negedge clk);

        // Random field pairs (R2, R3, R4, R6, R7)
        for (int k = 0; k < 10; k++) begin
            full_case(int'($urandom_range(15, 0)), int'($urandom_range(15, 0)));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule